// File: doc/BRIEF.md
# Chained Converter Serial Readout Controller

This block sits on the host side of a string of dual-channel current converters wired in series: each converter's serial output feeds the next one's serial input, and the last one drives the single data line into this controller. When the converters signal that a result set is ready, the controller pulls a low-active transmit enable, toggles a gated serial clock, and shifts in 40 bits per converter. Each converter supplies two 20-bit channel words. Every word lands in a small result memory that the host reads through a combinational read port.

Two scheduling modes are offered. In before-toggle mode the transfer starts from the falling edge of the data-valid strobe and must end before the next conversion toggle. In after-toggle mode the falling edge only arms the controller. Shifting begins after the next conversion toggle plus a programmable settle delay, and must end before new data becomes valid. In both modes a cycle budget bounds the transfer. If the configured bit count cannot finish inside it, or the forbidden event arrives early, the controller aborts cleanly and pulses an overrun flag.

Top module: `chain_readout_ctrl`

## Requirements
- R1: After reset, `xmit_n` is 1 and `dclk`, `done` and `overrun` are 0.
- R2: With `cfg_mode`=0, a falling edge of `dvalid_n` starts a transfer. `xmit_n` goes low `cfg_pre_wait`+1 clock cycles after the edge that detects the fall. `dclk` is never high while `xmit_n` is high.
- R3: `dclk` spends H clock cycles low and then H cycles high per bit, where H is `cfg_clk_div` and a value of 0 acts as 1. `sdata` is sampled at the clock edge that raises `dclk`. A completed transfer shows exactly 40·N rising edges of `dclk`.
- R4: The serial stream is taken nearest converter first. Within a converter, channel A comes before channel B, each word MSB first. The word of converter d, channel c (A=0, B=1) is stored at address 2·d+c and appears on `rd_data` when `rd_addr` selects it.
- R5: When all 40·N bits are in, `done` pulses for exactly one cycle. In that same cycle `xmit_n` is back at 1 and `dclk` is 0.
- R6: A transfer completes if and only if `cfg_window` ≥ `cfg_pre_wait` + 80·N·H. The budget counts from the start event. Otherwise `overrun` pulses once, `done` stays 0, and `xmit_n`=1, `dclk`=0 in that cycle. A transfer whose last bit completes in the cycle the budget runs out counts as complete.
- R7: With `cfg_mode`=1, a falling edge of `dvalid_n` arms the controller without driving `xmit_n`. Any change of `conv` then starts the budget. The first rising edge of `dclk` comes `cfg_pre_wait`+1+H cycles after the edge that detects that change.
- R8: During an active transfer (settle or shift), a change of `conv` in mode 0, or a new falling edge of `dvalid_n` in mode 1, aborts with `overrun` as in R6.
- R9: A device count of 0 is ignored: `xmit_n` stays high and no `done` follows. A count above `MAX_DEV` acts as `MAX_DEV`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0 = read before conversion toggle, 1 = read after it |
| cfg_dev_count | input | DEV_W | Number of chained converters N |
| cfg_clk_div | input | DIV_W | Half-period H of `dclk` in clock cycles |
| cfg_pre_wait | input | WIN_W | Settle delay in cycles before the enable drops |
| cfg_window | input | WIN_W | Cycle budget for settle plus shifting |
| dvalid_n | input | 1 | Data-ready strobe, falling edge = new results |
| conv | input | 1 | Conversion toggle signal |
| sdata | input | 1 | Serial data from the nearest converter |
| xmit_n | output | 1 | Transmit enable, active low |
| dclk | output | 1 | Gated serial data clock |
| done | output | 1 | One-cycle pulse at completion |
| overrun | output | 1 | One-cycle pulse on abort |
| rd_addr | input | AW | Result memory read address |
| rd_data | output | 20 | Result word at `rd_addr` |

## Verification
The final bit completing and the budget running out can fall in the same clock cycle. The bench provokes this by setting `cfg_window` to exactly `cfg_pre_wait`+80·N·H and then to one cycle less. It judges the pair by whether `done` or `overrun` pulses and by whether the stored words are intact. Randomized transfers place the budget just above or just below that line. Directed aborts fire the mode-specific forbidden event in the middle of shifting.

// File: rtl/crc_pkg.sv
package crc_pkg;

    localparam int WORD_BITS     = 20;
    localparam int WORDS_PER_DEV = 2;
    localparam int BIT_W         = 5;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_WAIT,
        ST_SHIFT
    } crc_state_e;

    typedef enum logic {
        MODE_BEFORE = 1'b0,
        MODE_AFTER  = 1'b1
    } crc_mode_e;

    typedef struct packed {
        logic                 valid;
        logic [WORD_BITS-1:0] data;
    } crc_word_t;

    function automatic logic is_last_bit(input logic [BIT_W-1:0] b);
        return b == LAST_BIT;
    endfunction

endpackage

// File: rtl/crc_edges.sv
module crc_edges (
    input  logic clk,
    input  logic rst,
    input  logic dvalid_n,
    input  logic conv,
    output logic dv_fall,
    output logic conv_tog
);
    logic dv_q;
    logic conv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dv_q   <= 1'b1;
            conv_q <= 1'b0;
        end else begin
            dv_q   <= dvalid_n;
            conv_q <= conv;
        end
    end

    assign dv_fall  = dv_q & ~dvalid_n;
    assign conv_tog = conv_q ^ conv;
endmodule

// File: rtl/crc_bit_engine.sv
module crc_bit_engine
    import crc_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int WC_W  = 5,
    parameter int AW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            run,
    input  logic            halt,
    input  logic [DIV_W-1:0] half,
    input  logic [WC_W-1:0] last_word,
    input  logic            sdata,
    output logic            dclk,
    output logic            fin,
    output crc_word_t       wr,
    output logic [AW-1:0]   wr_addr
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0]      ph;
    logic [PH_W-1:0]      half_m1;
    logic [PH_W-1:0]      full_m1;
    logic [BIT_W-1:0]     bitc;
    logic [WC_W-1:0]      wordc;
    logic [WORD_BITS-1:0] sh;
    logic [WORD_BITS-1:0] nxt;

    assign half_m1 = {1'b0, half} - 1'b1;
    assign full_m1 = {half, 1'b0} - 1'b1;
    assign nxt     = {sh[WORD_BITS-2:0], sdata};
    assign fin     = run && (ph == full_m1) && is_last_bit(bitc) && (wordc == last_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            bitc    <= '0;
            wordc   <= '0;
            sh      <= '0;
            dclk    <= 1'b0;
            wr      <= '0;
            wr_addr <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (start) begin
                ph    <= '0;
                bitc  <= '0;
                wordc <= '0;
                dclk  <= 1'b0;
            end else if (run && !halt) begin
                if (ph == half_m1) begin
                    dclk <= 1'b1;
                    sh   <= nxt;
                    ph   <= ph + 1'b1;
                    if (is_last_bit(bitc)) begin
                        wr.valid <= 1'b1;
                        wr.data  <= nxt;
                        wr_addr  <= wordc[AW-1:0];
                    end
                end else if (ph == full_m1) begin
                    dclk <= 1'b0;
                    ph   <= '0;
                    if (is_last_bit(bitc)) begin
                        bitc  <= '0;
                        wordc <= wordc + 1'b1;
                    end else begin
                        bitc <= bitc + 1'b1;
                    end
                end else begin
                    ph <= ph + 1'b1;
                end
            end else begin
                dclk <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/crc_result_mem.sv
module crc_result_mem
    import crc_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  crc_word_t            wr,
    input  logic [AW-1:0]        wr_addr,
    input  logic [AW-1:0]        rd_addr,
    output logic [WORD_BITS-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr.valid) begin
            mem[wr_addr] <= wr.data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl
    import crc_pkg::*;
#(
    parameter int MAX_DEV = 8,
    parameter int DIV_W   = 8,
    parameter int WIN_W   = 24,
    localparam int DEV_W  = $clog2(MAX_DEV + 1),
    localparam int AW     = $clog2(WORDS_PER_DEV * MAX_DEV)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_mode,
    input  logic [DEV_W-1:0]     cfg_dev_count,
    input  logic [DIV_W-1:0]     cfg_clk_div,
    input  logic [WIN_W-1:0]     cfg_pre_wait,
    input  logic [WIN_W-1:0]     cfg_window,
    input  logic                 dvalid_n,
    input  logic                 conv,
    input  logic                 sdata,
    output logic                 xmit_n,
    output logic                 dclk,
    output logic                 done,
    output logic                 overrun,
    input  logic [AW-1:0]        rd_addr,
    output logic [WORD_BITS-1:0] rd_data
);
    localparam int WC_W = DEV_W + 1;

    crc_state_e       state;
    crc_mode_e        mode_lat;
    logic [DEV_W-1:0] n_lat;
    logic [DIV_W-1:0] h_lat;
    logic [WIN_W-1:0] cnt;
    logic [WIN_W-1:0] wcnt;

    logic             dv_fall;
    logic             conv_tog;
    logic             fin;
    logic             active;
    logic             ext_abort;
    logic             abort;
    logic             start;
    logic [DEV_W-1:0] n_eff;
    logic [DIV_W-1:0] h_eff;
    logic [WC_W-1:0]  last_word;
    crc_word_t        wr;
    logic [AW-1:0]    wr_addr;

    crc_edges u_edges (
        .clk      (clk),
        .rst      (rst),
        .dvalid_n (dvalid_n),
        .conv     (conv),
        .dv_fall  (dv_fall),
        .conv_tog (conv_tog)
    );

    assign n_eff     = (cfg_dev_count > DEV_W'(MAX_DEV)) ? DEV_W'(MAX_DEV) : cfg_dev_count;
    assign h_eff     = (cfg_clk_div == '0) ? DIV_W'(1) : cfg_clk_div;
    assign last_word = {n_lat, 1'b0} - 1'b1;

    assign active    = (state == ST_WAIT) || (state == ST_SHIFT);
    assign ext_abort = (mode_lat == MODE_AFTER) ? dv_fall : conv_tog;
    assign abort     = active && !fin && ((wcnt == '0) || ext_abort);
    assign start     = (state == ST_WAIT) && (cnt == '0) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mode_lat <= MODE_BEFORE;
            n_lat    <= '0;
            h_lat    <= DIV_W'(1);
            cnt      <= '0;
            wcnt     <= '0;
            xmit_n   <= 1'b1;
            done     <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            done    <= 1'b0;
            overrun <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (dv_fall && (n_eff != '0)) begin
                        mode_lat <= crc_mode_e'(cfg_mode);
                        n_lat    <= n_eff;
                        h_lat    <= h_eff;
                        cnt      <= cfg_pre_wait;
                        wcnt     <= cfg_window;
                        state    <= cfg_mode ? ST_ARM : ST_WAIT;
                    end
                end
                ST_ARM: begin
                    if (conv_tog) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (abort) begin
                        state   <= ST_IDLE;
                        overrun <= 1'b1;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                        if (cnt == '0) begin
                            state  <= ST_SHIFT;
                            xmit_n <= 1'b0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (fin) begin
                        state  <= ST_IDLE;
                        xmit_n <= 1'b1;
                        done   <= 1'b1;
                    end else if (abort) begin
                        state   <= ST_IDLE;
                        xmit_n  <= 1'b1;
                        overrun <= 1'b1;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    crc_bit_engine #(
        .DIV_W (DIV_W),
        .WC_W  (WC_W),
        .AW    (AW)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .run       (state == ST_SHIFT),
        .halt      (abort),
        .half      (h_lat),
        .last_word (last_word),
        .sdata     (sdata),
        .dclk      (dclk),
        .fin       (fin),
        .wr        (wr),
        .wr_addr   (wr_addr)
    );

    crc_result_mem #(
        .AW (AW)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/crc_checker.sv
module crc_checker (
    input logic clk,
    input logic rst,
    input logic xmit_n,
    input logic dclk,
    input logic done,
    input logic overrun
);
    // R1: the cycle after reset is held, all outputs are at rest
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (xmit_n && !dclk && !done && !overrun));

    p_clk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        xmit_n |-> !dclk);

    p_rise_enabled_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk) |-> !xmit_n);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_release_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (xmit_n && !dclk && $past(!xmit_n)));

    p_abort_clean_r6: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (xmit_n && !dclk));

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(done && overrun));

    p_abort_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);
endmodule

bind chain_readout_ctrl crc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .xmit_n  (xmit_n),
    .dclk    (dclk),
    .done    (done),
    .overrun (overrun)
);

// File: tb/chain_readout_ctrl_bench.sv
module chain_readout_ctrl_bench;
    localparam int PERIOD  = 10;
    localparam int MAX_DEV = 8;
    localparam int DIV_W   = 8;
    localparam int WIN_W   = 24;
    localparam int DEV_W   = 4;
    localparam int AW      = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_mode = 1'b0;
    logic [DEV_W-1:0]  cfg_dev_count = '0;
    logic [DIV_W-1:0]  cfg_clk_div = 8'd1;
    logic [WIN_W-1:0]  cfg_pre_wait = '0;
    logic [WIN_W-1:0]  cfg_window = '0;
    logic              dvalid_n = 1'b1;
    logic              conv = 1'b0;
    logic              sdata;
    logic              xmit_n, dclk, done, overrun;
    logic [AW-1:0]     rd_addr = '0;
    logic [19:0]       rd_data;

    int   nchk = 0;
    int   nerr = 0;
    logic [19:0] exp_w [2*MAX_DEV];
    int   bit_idx = 0;
    int   rises = 0;
    int   xlow = 0;
    int   done_cnt = 0;
    int   ovr_cnt = 0;
    int   viol = 0;
    time  first_rise = 0;
    time  first_xlow = 0;
    logic dclk_d = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    chain_readout_ctrl u_chain_readout_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dev_count(cfg_dev_count),
        .cfg_clk_div(cfg_clk_div), .cfg_pre_wait(cfg_pre_wait), .cfg_window(cfg_window),
        .dvalid_n(dvalid_n), .conv(conv), .sdata(sdata), .xmit_n(xmit_n), .dclk(dclk),
        .done(done), .overrun(overrun), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // chain model: bit stream nearest converter first, A then B, MSB first
    always_comb begin
        if (bit_idx / 20 < 2*MAX_DEV) sdata = exp_w[bit_idx / 20][19 - (bit_idx % 20)];
        else                          sdata = 1'b0;
    end

    always @(negedge clk) begin
        if (dclk && !dclk_d) begin
            rises = rises + 1;
            bit_idx = bit_idx + 1;
            if (rises == 1) first_rise = $time;
        end
        dclk_d = dclk;
        if (!xmit_n) begin
            if (xlow == 0) first_xlow = $time;
            xlow = xlow + 1;
        end
        if (done) done_cnt = done_cnt + 1;
        if (overrun) ovr_cnt = ovr_cnt + 1;
        if (xmit_n && dclk) viol = viol + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int clamp_n(input int n);
        return (n > MAX_DEV) ? MAX_DEV : n;
    endfunction

    function automatic int eff_h(input int h);
        return (h == 0) ? 1 : h;
    endfunction

    function automatic bit fits(input int n, input int h, input int pre, input int win);
        return win >= pre + 80 * clamp_n(n) * eff_h(h);
    endfunction

    task automatic begin_xfer(input bit mode, input int n, input int h, input int pre,
                              input int win, output time t_evt);
        for (int i = 0; i < 2*MAX_DEV; i++) exp_w[i] = 20'($urandom);
        @(negedge clk);
        t_evt = $time;
        #1;
        cfg_mode = mode; cfg_dev_count = DEV_W'(n); cfg_clk_div = DIV_W'(h);
        cfg_pre_wait = WIN_W'(pre); cfg_window = WIN_W'(win);
        bit_idx = 0; rises = 0; done_cnt = 0; ovr_cnt = 0; xlow = 0; viol = 0;
        first_rise = 0; first_xlow = 0;
        dvalid_n = 1'b0;
        if (mode) begin
            repeat (3) @(negedge clk);
            t_evt = $time;
            #1 conv = ~conv;
        end
    endtask

    task automatic wait_end(output bit timed_out);
        int tmo = 0;
        while (done_cnt == 0 && ovr_cnt == 0 && tmo < 60000) begin
            @(negedge clk); #2; tmo++;
        end
        timed_out = (tmo >= 60000);
    endtask

    task automatic finish_xfer();
        @(negedge clk); #1 dvalid_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_xfer(input bit mode, input int n, input int h, input int pre, input int win);
        time t_evt;
        bit  to;
        int  nc = clamp_n(n);
        int  hc = eff_h(h);
        bit  ok = fits(n, h, pre, win);
        begin_xfer(mode, n, h, pre, win, t_evt);
        wait_end(to);
        chk(!to, "R6 transfer ended", to, 0);
        chk(done_cnt == int'(ok), "R6 done versus budget", done_cnt, int'(ok));
        chk(ovr_cnt == int'(!ok), "R6 overrun versus budget", ovr_cnt, int'(!ok));
        chk(xmit_n && !dclk, "R5 released at end", {xmit_n, dclk}, 2);
        if (ok) begin
            chk(rises == 40*nc, "R3 rising edge count", rises, 40*nc);
            if (mode) chk(int'((first_rise - t_evt) / PERIOD) == pre + 2 + hc,
                          "R7 first rise after toggle", (first_rise - t_evt) / PERIOD, pre + 2 + hc);
            else      chk(int'((first_xlow - t_evt) / PERIOD) == pre + 2,
                          "R2 enable delay", (first_xlow - t_evt) / PERIOD, pre + 2);
            for (int a = 0; a < 2*nc; a++) begin
                rd_addr = AW'(a);
                #1;
                chk(rd_data == exp_w[a], "R4 stored word", rd_data, exp_w[a]);
            end
        end
        chk(viol == 0, "R2 dclk idle while disabled", viol, 0);
        finish_xfer();
    endtask

    task automatic run_abort(input bit mode);
        time t_evt;
        bit  to;
        int  tmo = 0;
        begin_xfer(mode, 4, 2, 2, 100000, t_evt);
        while (rises < 5 && tmo < 5000) begin @(negedge clk); #2; tmo++; end
        if (mode) begin
            dvalid_n = 1'b1; @(negedge clk); #1 dvalid_n = 1'b0;
        end else begin
            conv = ~conv;
        end
        wait_end(to);
        chk(ovr_cnt == 1 && done_cnt == 0, "R8 forbidden event aborts", ovr_cnt, 1);
        chk(xmit_n && !dclk, "R8 clean abort", {xmit_n, dclk}, 2);
        chk(rises < 160, "R8 shifting stopped early", rises, 159);
        finish_xfer();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); #1 rst = 1'b0;
        @(negedge clk); #1;
        chk(xmit_n == 1'b1, "R1 xmit_n after reset", xmit_n, 1);
        chk(dclk == 1'b0 && done == 1'b0 && overrun == 1'b0, "R1 outputs after reset",
            {dclk, done, overrun}, 0);

        // directed: smallest chain, fastest clock, ample budget
        run_xfer(1'b0, 1, 1, 0, 1000);
        // exact-budget corner: completion and exhaustion in the same cycle
        run_xfer(1'b0, 2, 2, 3, 3 + 80*2*2);
        run_xfer(1'b0, 2, 2, 3, 3 + 80*2*2 - 1);
        // after-toggle scheduling
        run_xfer(1'b1, 3, 3, 7, 5000);
        run_xfer(1'b1, 1, 1, 0, 80);
        // divider value 0 acts as 1 (R3)
        run_xfer(1'b0, 2, 0, 1, 1000);
        // count above maximum is clamped (R9)
        run_xfer(1'b0, 13, 1, 0, 100000);
        chk(rises == 40*MAX_DEV, "R9 clamped device count", rises, 40*MAX_DEV);
        // forbidden events (R8)
        run_abort(1'b0);
        run_abort(1'b1);

        // count of zero is ignored (R9)
        begin
            time t_evt;
            begin_xfer(1'b0, 0, 1, 0, 1000, t_evt);
            repeat (60) @(negedge clk);
            #2;
            chk(xlow == 0 && done_cnt == 0 && ovr_cnt == 0, "R9 zero count ignored",
                xlow + done_cnt + ovr_cnt, 0);
            finish_xfer();
        end

        // constrained random transfers around the budget line
        for (int k = 0; k < 14; k++) begin
            bit m  = 1'($urandom % 2);
            int n  = 1 + int'($urandom % MAX_DEV);
            int h  = 1 + int'($urandom % 4);
            int p  = int'($urandom % 16);
            int nd = p + 80*n*h;
            int w  = ($urandom % 2) ? nd + int'($urandom % 5) : nd - 1 - int'($urandom % 40);
            run_xfer(m, n, h, p, w);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule